// File: doc/BRIEF.md
# Overriding Next-PC Pipeline Controller

This block drives a three-stage branch prediction pipeline. In every cycle it picks the start address of the next fetch block, `s0_pc_o`. It also tells each stage whether it is doing useful work this cycle. A fast predictor answers for the block in stage 1 in the same cycle. Its next-PC goes straight back to stage 0, so blocks flow at one per cycle with no gaps. Two slower predictors answer for the same block one and two cycles later, in stages 2 and 3.

The controller keeps a registered copy of the answer each earlier stage gave for a block. It compares that copy with the later answer for the same block. When they disagree, the later stage wins: its next-PC is steered into stage 0, its redirect flag is raised, and the younger blocks behind it are squashed. An external redirect overrides everything and restarts prediction from a recovery PC. The predictors themselves are outside the block; their results arrive on input ports. Each stage's PC is presented on an output so the predictors can index with it.

Top module: `npc_override_ctrl`

## Requirements
- R1: While `rst_ni` is low, `s0_pc_o` equals `RESET_VEC` and all fire and redirect outputs are 0. The first rising edge after reset release sets `s0_fire_o` to 1. One cycle later, stage 1 fires with `s1_pc_o` equal to `RESET_VEC`.
- R2: Whenever `s0_fire_o` is 1, the next cycle's `s1_pc_o` equals this cycle's `s0_pc_o`. While stage 1 fires and no redirect is active, `s0_pc_o` is `s1_target_i` if `s1_hit_i` and `s1_taken_i` are both 1. Otherwise it is `s1_pc_o + BLOCK_BYTES`. Both cases take effect in the same cycle.
- R3: When `s1_hit_i` is 0, the values of `s1_taken_i` and `s1_target_i` have no effect. `s0_pc_o` is `s1_pc_o + BLOCK_BYTES`, and the block is recorded as not taken for the stage-2 comparison.
- R4: `s2_redirect_o` is raised when stage 2 holds a valid block and its result differs from the stage-1 result recorded for that block one cycle earlier. The results differ when the taken flags differ, or when both are taken with different targets. A matching result raises no redirect.
- R5: On `s2_redirect_o`, `s0_pc_o` is the stage-2 next-PC: `s2_target_i` if `s2_taken_i` is 1, else `s2_pc_o + BLOCK_BYTES`. `s1_fire_o` is 0 in the same cycle. `s2_fire_o` is 0 in the following cycle.
- R6: `s3_redirect_o` is raised when stage 3 holds a valid block and its result differs from the stage-2 result recorded for that block, using the rule of R4. When it is raised:
  - `s0_pc_o` is the stage-3 next-PC;
  - `s1_fire_o`, `s2_fire_o` and `s2_redirect_o` are 0 in that cycle;
  - `s2_fire_o` and `s3_fire_o` are 0 in the next cycle.
- R7: While `ext_redirect_i` is 1, `s1_fire_o`, `s2_fire_o`, `s3_fire_o`, `s2_redirect_o` and `s3_redirect_o` are all 0. In the next cycle, stage 1 fires with `s1_pc_o` equal to the redirect PC.
- R8: A stage whose predecessor did not fire in the previous cycle is idle: its fire output is 0 and it raises no redirect, whatever its result inputs carry.
- R9: `s0_pc_o` is chosen in this priority order:
  1. external redirect PC;
  2. stage-3 redirect;
  3. stage-2 redirect;
  4. stage-1 next-PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s1_hit_i | input | 1 | Fast predictor has a prediction for the stage-1 block |
| s1_taken_i | input | 1 | Fast predictor: block ends in a taken branch |
| s1_target_i | input | PC_W | Fast predictor: taken target |
| s2_taken_i | input | 1 | Stage-2 predictor: block ends in a taken branch |
| s2_target_i | input | PC_W | Stage-2 predictor: taken target |
| s3_taken_i | input | 1 | Stage-3 predictor: block ends in a taken branch |
| s3_target_i | input | PC_W | Stage-3 predictor: taken target |
| ext_redirect_i | input | 1 | External redirect request |
| ext_pc_i | input | PC_W | Recovery PC for the external redirect |
| s0_pc_o | output | PC_W | Start address of the next prediction block |
| s1_pc_o | output | PC_W | Block address in stage 1 |
| s2_pc_o | output | PC_W | Block address in stage 2 |
| s3_pc_o | output | PC_W | Block address in stage 3 |
| s0_fire_o | output | 1 | Stage 0 active |
| s1_fire_o | output | 1 | Stage 1 active |
| s2_fire_o | output | 1 | Stage 2 active |
| s3_fire_o | output | 1 | Stage 3 active |
| s2_redirect_o | output | 1 | Stage 2 overrides the stage-1 guess |
| s3_redirect_o | output | 1 | Stage 3 overrides the stage-2 result |

## Verification
The hardest condition to reach is a stage-3 mismatch that arrives while stage 2 also disagrees with its own recorded guess. In that case the stage-2 redirect must be masked, and the two-cycle bubble in stages 2 and 3 must follow.

To get there, the stimulus first restarts the pipeline from a known base with an external redirect. It then lets the pipeline fill for two cycles, so every stage holds a block with a known recorded result. Finally, in one cycle, it drives conflicting results into both slow stages.

Agreement cases drive the slow-stage inputs to match the recorded guess one and two cycles after the guess is made. A mismatch, or a missing squash, then shows up in `s0_pc_o` or in the fire outputs.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_S1,
    SRC_S2,
    SRC_S3,
    SRC_EXT
  } npc_src_e;
endpackage

// File: rtl/npc_stage.sv
// Pipeline register for stage 2 or 3: block PC plus the result recorded by the previous stage.
module npc_stage #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_in_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            rec_taken_i,
  input  logic [PC_W-1:0] rec_tgt_i,
  output logic            vld_o,
  output logic [PC_W-1:0] pc_o,
  output logic            rec_taken_o,
  output logic [PC_W-1:0] rec_tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      pc_o        <= '0;
      rec_taken_o <= 1'b0;
      rec_tgt_o   <= '0;
    end else begin
      vld_o <= fire_in_i;
      if (fire_in_i) begin
        pc_o        <= pc_i;
        rec_taken_o <= rec_taken_i;
        rec_tgt_o   <= rec_tgt_i;
      end
    end
  end
endmodule

// File: rtl/npc_diff.sv
// Mismatch between the recorded result and the later result for the same block.
module npc_diff #(
  parameter int unsigned PC_W = 32
) (
  input  logic            vld_i,
  input  logic            rec_taken_i,
  input  logic [PC_W-1:0] rec_tgt_i,
  input  logic            new_taken_i,
  input  logic [PC_W-1:0] new_tgt_i,
  output logic            mism_o
);
  logic dir_diff;
  logic tgt_diff;

  assign dir_diff = rec_taken_i ^ new_taken_i;
  assign tgt_diff = rec_taken_i & new_taken_i & (rec_tgt_i != new_tgt_i);
  assign mism_o   = vld_i & (dir_diff | tgt_diff);
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            ext_i,
  input  logic [PC_W-1:0] ext_pc_i,
  input  logic            s3_redir_i,
  input  logic [PC_W-1:0] s3_npc_i,
  input  logic            s2_redir_i,
  input  logic [PC_W-1:0] s2_npc_i,
  input  logic            s1_fire_i,
  input  logic [PC_W-1:0] s1_npc_i,
  input  logic [PC_W-1:0] hold_pc_i,
  output logic [PC_W-1:0] npc_o
);
  npc_src_e src;

  always_comb begin
    if (ext_i)           src = SRC_EXT;
    else if (s3_redir_i) src = SRC_S3;
    else if (s2_redir_i) src = SRC_S2;
    else if (s1_fire_i)  src = SRC_S1;
    else                 src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_EXT: npc_o = ext_pc_i;
      SRC_S3:  npc_o = s3_npc_i;
      SRC_S2:  npc_o = s2_npc_i;
      SRC_S1:  npc_o = s1_npc_i;
      default: npc_o = hold_pc_i;
    endcase
  end
endmodule

// File: rtl/npc_override_ctrl.sv
module npc_override_ctrl #(
  parameter int unsigned    PC_W        = 32,
  parameter int unsigned    BLOCK_BYTES = 32,
  parameter logic [PC_W-1:0] RESET_VEC  = 'h100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            s1_hit_i,
  input  logic            s1_taken_i,
  input  logic [PC_W-1:0] s1_target_i,
  input  logic            s2_taken_i,
  input  logic [PC_W-1:0] s2_target_i,
  input  logic            s3_taken_i,
  input  logic [PC_W-1:0] s3_target_i,
  input  logic            ext_redirect_i,
  input  logic [PC_W-1:0] ext_pc_i,
  output logic [PC_W-1:0] s0_pc_o,
  output logic [PC_W-1:0] s1_pc_o,
  output logic [PC_W-1:0] s2_pc_o,
  output logic [PC_W-1:0] s3_pc_o,
  output logic            s0_fire_o,
  output logic            s1_fire_o,
  output logic            s2_fire_o,
  output logic            s3_fire_o,
  output logic            s2_redirect_o,
  output logic            s3_redirect_o
);
  localparam int unsigned NSTG = 3;
  localparam logic [PC_W-1:0] STEP = PC_W'(BLOCK_BYTES);

  // index 0 = stage 1, 1 = stage 2, 2 = stage 3
  logic            st_vld    [NSTG];
  logic [PC_W-1:0] st_pc     [NSTG];
  logic            res_taken [NSTG];
  logic [PC_W-1:0] res_tgt   [NSTG];
  logic [PC_W-1:0] res_npc   [NSTG];
  logic            st_fire   [NSTG];
  logic            rec_taken [NSTG-1];
  logic [PC_W-1:0] rec_tgt   [NSTG-1];
  logic            mism      [NSTG-1];

  logic            live_q;
  logic            s1_vld_q;
  logic [PC_W-1:0] s1_pc_q;
  logic [PC_W-1:0] hold_pc_q;
  logic [PC_W-1:0] npc;
  logic            s2_redir;
  logic            s3_redir;

  // the fast predictor's taken flag counts only on a hit
  assign res_taken[0] = s1_hit_i & s1_taken_i;
  assign res_tgt[0]   = s1_target_i;
  assign res_taken[1] = s2_taken_i;
  assign res_tgt[1]   = s2_target_i;
  assign res_taken[2] = s3_taken_i;
  assign res_tgt[2]   = s3_target_i;

  assign st_vld[0] = s1_vld_q;
  assign st_pc[0]  = s1_pc_q;

  for (genvar k = 0; k < NSTG; k++) begin : g_npc
    assign res_npc[k] = res_taken[k] ? res_tgt[k] : st_pc[k] + STEP;
  end

  for (genvar k = 0; k < NSTG - 1; k++) begin : g_late
    npc_stage #(.PC_W(PC_W)) u_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fire_in_i   (st_fire[k]),
      .pc_i        (st_pc[k]),
      .rec_taken_i (res_taken[k]),
      .rec_tgt_i   (res_tgt[k]),
      .vld_o       (st_vld[k+1]),
      .pc_o        (st_pc[k+1]),
      .rec_taken_o (rec_taken[k]),
      .rec_tgt_o   (rec_tgt[k])
    );

    npc_diff #(.PC_W(PC_W)) u_diff (
      .vld_i       (st_vld[k+1]),
      .rec_taken_i (rec_taken[k]),
      .rec_tgt_i   (rec_tgt[k]),
      .new_taken_i (res_taken[k+1]),
      .new_tgt_i   (res_tgt[k+1]),
      .mism_o      (mism[k])
    );
  end

  assign s3_redir = mism[1] & ~ext_redirect_i;
  assign s2_redir = mism[0] & ~ext_redirect_i & ~s3_redir;

  assign st_fire[0] = st_vld[0] & ~ext_redirect_i & ~s3_redir & ~s2_redir;
  assign st_fire[1] = st_vld[1] & ~ext_redirect_i & ~s3_redir;
  assign st_fire[2] = st_vld[2] & ~ext_redirect_i;

  npc_select #(.PC_W(PC_W)) u_sel (
    .ext_i      (ext_redirect_i),
    .ext_pc_i   (ext_pc_i),
    .s3_redir_i (s3_redir),
    .s3_npc_i   (res_npc[2]),
    .s2_redir_i (s2_redir),
    .s2_npc_i   (res_npc[1]),
    .s1_fire_i  (st_fire[0]),
    .s1_npc_i   (res_npc[0]),
    .hold_pc_i  (hold_pc_q),
    .npc_o      (npc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q    <= 1'b0;
      s1_vld_q  <= 1'b0;
      s1_pc_q   <= '0;
      hold_pc_q <= RESET_VEC;
    end else begin
      live_q    <= 1'b1;
      s1_vld_q  <= live_q;
      hold_pc_q <= npc;
      if (live_q) s1_pc_q <= npc;
    end
  end

  assign s0_pc_o       = npc;
  assign s1_pc_o       = st_pc[0];
  assign s2_pc_o       = st_pc[1];
  assign s3_pc_o       = st_pc[2];
  assign s0_fire_o     = live_q;
  assign s1_fire_o     = st_fire[0];
  assign s2_fire_o     = st_fire[1];
  assign s3_fire_o     = st_fire[2];
  assign s2_redirect_o = s2_redir;
  assign s3_redirect_o = s3_redir;
endmodule

// File: rtl/npc_override_ctrl_chk.sv
module npc_override_ctrl_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ext_redirect_i,
  input logic [PC_W-1:0] ext_pc_i,
  input logic [PC_W-1:0] s0_pc_o,
  input logic [PC_W-1:0] s1_pc_o,
  input logic            s0_fire_o,
  input logic            s1_fire_o,
  input logic            s2_fire_o,
  input logic            s3_fire_o,
  input logic            s2_redirect_o,
  input logic            s3_redirect_o
);
  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s0_fire_o |=> s1_pc_o == $past(s0_pc_o)); // R2

  AST_S2_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_redirect_o |-> !s1_fire_o ##1 !s2_fire_o); // R5

  AST_S3_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_redirect_o |-> !s1_fire_o && !s2_fire_o && !s2_redirect_o); // R6

  AST_S3_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_redirect_o |=> !s2_fire_o && !s3_fire_o); // R6

  AST_EXT_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_redirect_i |-> !s1_fire_o && !s2_fire_o && !s3_fire_o
                       && !s2_redirect_o && !s3_redirect_o); // R7

  AST_EXT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_redirect_i |-> s0_pc_o == ext_pc_i); // R9

  AST_S2_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_fire_o |-> $past(s1_fire_o)); // R8

  AST_S3_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_fire_o |-> $past(s2_fire_o)); // R8

  AST_REDIR_NEEDS_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_redirect_o |-> s2_fire_o) and (s3_redirect_o |-> s3_fire_o)); // R8
endmodule

bind npc_override_ctrl npc_override_ctrl_chk #(.PC_W(PC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ext_redirect_i (ext_redirect_i),
  .ext_pc_i       (ext_pc_i),
  .s0_pc_o        (s0_pc_o),
  .s1_pc_o        (s1_pc_o),
  .s0_fire_o      (s0_fire_o),
  .s1_fire_o      (s1_fire_o),
  .s2_fire_o      (s2_fire_o),
  .s3_fire_o      (s3_fire_o),
  .s2_redirect_o  (s2_redirect_o),
  .s3_redirect_o  (s3_redirect_o)
);

// File: tb/npc_override_ctrl_bench.sv
`timescale 1ns/1ps
module npc_override_ctrl_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          PC_W       = 32;
  localparam logic [31:0] BLK        = 32;
  localparam logic [31:0] RVEC       = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        s1_hit, s1_taken, s2_taken, s3_taken, ext;
  logic [31:0] s1_tgt, s2_tgt, s3_tgt, ext_pc;
  logic [31:0] s0_pc, s1_pc, s2_pc, s3_pc;
  logic        f0, f1, f2, f3, r2, r3;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_override_ctrl #(.PC_W(PC_W), .BLOCK_BYTES(32), .RESET_VEC(RVEC)) u_npc_override_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .s1_hit_i(s1_hit), .s1_taken_i(s1_taken), .s1_target_i(s1_tgt),
    .s2_taken_i(s2_taken), .s2_target_i(s2_tgt),
    .s3_taken_i(s3_taken), .s3_target_i(s3_tgt),
    .ext_redirect_i(ext), .ext_pc_i(ext_pc),
    .s0_pc_o(s0_pc), .s1_pc_o(s1_pc), .s2_pc_o(s2_pc), .s3_pc_o(s3_pc),
    .s0_fire_o(f0), .s1_fire_o(f1), .s2_fire_o(f2), .s3_fire_o(f3),
    .s2_redirect_o(r2), .s3_redirect_o(r3)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    s1_hit = 1'b1; s1_taken = 1'b0; s1_tgt = '0;
    s2_taken = 1'b0; s2_tgt = '0;
    s3_taken = 1'b0; s3_tgt = '0;
    ext = 1'b0; ext_pc = '0;
  endtask

  // advance one cycle; inputs are then driven in the low phase
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  // external redirect to base, then s1 holds base in the next cycle
  task automatic restart(input logic [31:0] base);
    idle(); ext = 1'b1; ext_pc = base; settle();
    chk("R7 s0_pc on ext", s0_pc, base);
    chk("R7 s1_fire on ext", f1, 0);
    chk("R7 s2_fire on ext", f2, 0);
    chk("R7 s3_fire on ext", f3, 0);
    tick(); idle(); settle();
    chk("R7 s1_pc after ext", s1_pc, base);
    chk("R7 s1_fire after ext", f1, 1);
    chk("R8 s2_fire after ext", f2, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle();
    repeat (3) @(posedge clk);
    @(negedge clk); settle();
    chk("R1 s0_pc in reset", s0_pc, RVEC);
    chk("R1 s0_fire in reset", f0, 0);
    chk("R1 fires in reset", {f1, f2, f3, r2, r3}, 0);
    rst_n = 1'b1; settle();
    chk("R1 s0_fire before first edge", f0, 0);
    tick(); settle();
    chk("R1 s0_fire after edge", f0, 1);
    chk("R1 s1_fire empty", f1, 0);
    chk("R1 s0_pc hold", s0_pc, RVEC);
    tick(); settle();
    chk("R1 s1_pc first block", s1_pc, RVEC);
    chk("R2 s0_pc fallthrough", s0_pc, RVEC + BLK);
    tick(); settle();
    chk("R2 s1_pc follows s0_pc", s1_pc, RVEC + BLK);
    chk("R2 s0_pc stream", s0_pc, RVEC + 2*BLK);
    chk("R8 s2 first fire", f2, 1);
  endtask

  task automatic t_s1_taken();
    logic [31:0] b = 32'h1000, t = 32'h6000;
    restart(b); tick();
    s1_hit = 1'b1; s1_taken = 1'b1; s1_tgt = t; settle();
    chk("R2 s0_pc s1 taken", s0_pc, t);
    tick(); idle(); s2_taken = 1'b1; s2_tgt = t; settle();
    chk("R4 s2 agrees no redirect", r2, 0);
    chk("R2 s1_pc taken target", s1_pc, t);
    chk("R2 s0_pc after taken", s0_pc, t + BLK);
    tick(); idle(); s3_taken = 1'b1; s3_tgt = t; settle();
    chk("R6 s3 agrees no redirect", r3, 0);
    chk("R4 s2 nt agrees", r2, 0);
    chk("R2 s0_pc stream after taken", s0_pc, t + 2*BLK);
  endtask

  task automatic t_target_diff();
    logic [31:0] b = 32'h1400, t = 32'h6000, t2 = 32'h6100;
    restart(b); tick();
    s1_taken = 1'b1; s1_tgt = t; settle();
    tick(); idle(); s2_taken = 1'b1; s2_tgt = t2; settle();
    chk("R4 target-only mismatch", r2, 1);
    chk("R5 s0_pc s2 target", s0_pc, t2);
    chk("R5 s1 squashed", f1, 0);
  endtask

  task automatic t_s1_miss();
    logic [31:0] b = 32'h1800;
    restart(b); tick();
    s1_hit = 1'b0; s1_taken = 1'b1; s1_tgt = 32'h7000; settle();
    chk("R3 miss ignores target", s0_pc, b + 2*BLK);
    tick(); idle(); settle();
    chk("R3 miss recorded not taken", r2, 0);
    chk("R3 s0_pc after miss", s0_pc, b + 3*BLK);
  endtask

  task automatic t_s2_override();
    logic [31:0] b = 32'h1000, u = 32'h2000;
    restart(b); tick(); tick();
    s2_taken = 1'b1; s2_tgt = u; settle();
    chk("R4 s2 direction mismatch", r2, 1);
    chk("R5 s0_pc from s2", s0_pc, u);
    chk("R5 s1 squashed", f1, 0);
    chk("R5 s2 still fires", f2, 1);
    tick(); s3_taken = 1'b1; s3_tgt = u; settle();
    chk("R5 s2 bubble", f2, 0);
    chk("R8 idle s2 no redirect", r2, 0);
    chk("R6 s3 agrees with s2", r3, 0);
    chk("R5 s1_pc corrected", s1_pc, u);
    chk("R5 s0_pc after override", s0_pc, u + BLK);
    tick(); idle(); settle();
    chk("R8 s3 bubble", f3, 0);
    chk("R5 s2 refills", f2, 1);
    chk("R5 s0_pc refill", s0_pc, u + 2*BLK);
  endtask

  task automatic t_s3_override();
    logic [31:0] b = 32'h1000, v = 32'h3000;
    restart(b); tick(); tick();
    s3_taken = 1'b1; s3_tgt = v; s2_taken = 1'b1; s2_tgt = 32'h3800; settle();
    chk("R6 s3 redirect", r3, 1);
    chk("R9 s3 over s2", r2, 0);
    chk("R9 s0_pc from s3", s0_pc, v);
    chk("R6 s1 squashed", f1, 0);
    chk("R6 s2 squashed", f2, 0);
    chk("R6 s3 fires", f3, 1);
    tick(); idle(); settle();
    chk("R6 s2 bubble", f2, 0);
    chk("R6 s3 bubble", f3, 0);
    chk("R6 s0_pc after s3", s0_pc, v + BLK);
    tick(); settle();
    chk("R6 s2 refill", f2, 1);
    chk("R8 s3 still idle", f3, 0);
    tick(); settle();
    chk("R6 s3 refill", f3, 1);
    chk("R6 s0_pc stream", s0_pc, v + 3*BLK);
  endtask

  task automatic t_ext_priority();
    logic [31:0] b = 32'h1000, w = 32'h4000;
    restart(b); tick(); tick();
    ext = 1'b1; ext_pc = w; s3_taken = 1'b1; s3_tgt = 32'h5000;
    s2_taken = 1'b1; s2_tgt = 32'h5800; settle();
    chk("R9 ext wins", s0_pc, w);
    chk("R7 redirects masked", {r2, r3}, 0);
    chk("R7 fires masked", {f1, f2, f3}, 0);
    tick(); idle(); settle();
    chk("R7 s1_pc restart", s1_pc, w);
    chk("R7 s0_pc restart", s0_pc, w + BLK);
    chk("R8 s3 idle after ext", f3, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_s1_taken();
    t_target_diff();
    t_s1_miss();
    t_s2_override();
    t_s3_override();
    t_ext_priority();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule